// File: doc/BRIEF.md
# Interrupt Latch and Context Stacking Sequencer

This block sits between the interrupt sources of a small 8-bit processor and its core. It records each request pulse in a pending latch. When the core is idle it picks one winner, once, and turns it into a fixed vector code. It then drives a byte-wide bus through a fixed series of cycles:

- five stack writes that save the program counter, the index register, the accumulator and the condition code register;
- two reads of the vector bytes.

At the end it hands the core a new program counter, a decremented stack pointer and a condition code byte with the interrupt mask bit set.

A return request runs the opposite series. One dummy read comes first. Then five pops restore the saved context, and the mask bit comes back as it was stacked.

Software interrupts use the same path and ignore the mask. While a sequence is running, the chosen code is frozen. Requests that arrive later wait in the pending latch.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is held and on release, `busy`, `done`, `bus_wr` and `bus_rd` are 0 and all context outputs are 0.
- R2: A one-cycle request pulse is remembered until serviced. A hardware request is not started while bit 3 of `ccr_in` (the mask bit) is 1, and it is started once that bit reads 0.
- R3: Among pending, unmasked requests, a software request (code 0) wins over all hardware ones. Hardware source i has code i+1, and the lower index wins. A software request is started even when the mask bit is 1.
- R4: The vector high byte is read at `VEC_BASE - 2*code` and the low byte at the next address. `pc_out` becomes {high, low}.
- R5: An entry writes five bytes to descending addresses starting at `sp_in`, in this order: PC low, PC high, X, A, CCR.
- R6: After an entry, `ccr_out` equals the snapshot CCR with bit 3 set, `a_out` and `x_out` equal the snapshots, and `sp_out` equals `sp_in - 5`.
- R7: `vec_code` stays constant while `busy` is high. A request arriving during a sequence cannot displace the running one and is serviced afterwards.
- R8: A return does one dummy read at `sp_in`, then reads `sp_in+1` to `sp_in+5` into CCR, A, X, PC high and PC low. Afterwards `sp_out` is `sp_in + 5` and `ccr_out` is the stacked byte, including its mask bit.
- R9: Stack addresses and `sp_out` wrap modulo 2^16.
- R10: `done` is a one-cycle pulse with `busy` low.
  - For an entry it comes 8 clock edges after the edge that samples the request.
  - For a return it comes 6 edges after the edge that samples `rti_req`.
  - `bus_wr` and `bus_rd` are never high together.
- R11: When `rti_req` and a pending interrupt are both present in an idle cycle, the return is taken first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Hardware request pulses, bit i = source i |
| swi_req | input | 1 | Software interrupt request pulse |
| rti_req | input | 1 | Return-from-interrupt request pulse |
| ccr_in | input | DATA_W | CCR snapshot; bit I_POS is the mask |
| a_in | input | DATA_W | Accumulator snapshot |
| x_in | input | DATA_W | Index register snapshot |
| pc_in | input | ADDR_W | Program counter snapshot |
| sp_in | input | ADDR_W | Stack pointer snapshot |
| bus_rdata | input | DATA_W | Read data for the current bus address |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_wr | output | 1 | Write cycle |
| bus_rd | output | 1 | Read cycle |
| ccr_out | output | DATA_W | Resulting CCR |
| a_out | output | DATA_W | Resulting accumulator |
| x_out | output | DATA_W | Resulting index register |
| pc_out | output | ADDR_W | Resulting program counter |
| sp_out | output | ADDR_W | Resulting stack pointer |
| vec_code | output | CODE_W | Latched arbitration code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished strobe |

## Verification
The properties assume the core only raises `rti_req` in an idle cycle. They also assume `bus_rdata` is valid in the same cycle as the address it belongs to. The bench meets both: it drives every input at the falling edge, pulses `rti_req` only in a cycle where `done` is high or `busy` is low, and returns memory data combinationally from the address. The properties put no limit on request pulses during a sequence. The bench deliberately raises a higher-priority request in the middle of a stacking run.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PUSH,
      SQ_VHI,
      SQ_VLO,
      SQ_DUMMY,
      SQ_POP
   } seq_st_t;

   localparam int STEP_W    = 3;
   localparam int LAST_STEP = 4;

endpackage

// File: rtl/irq_latch_arb.sv
module irq_latch_arb #(
   parameter int NUM_SRC = 8,
   parameter int CODE_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] req,
   input  logic              swi,
   input  logic              ibit,
   input  logic              take,
   output logic              any,
   output logic [CODE_W-1:0] win
);
   localparam int NPEND = NUM_SRC + 1;

   logic [NPEND-1:0] req_all;
   logic [NPEND-1:0] pend;
   logic [NPEND-1:0] elig;

   assign req_all = {req, swi};

   for (genvar j = 0; j < NPEND; j++) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[j] <= 1'b0;
         else        pend[j] <= (pend[j] & ~(take && win == CODE_W'(j))) | req_all[j];
      end
      if (j == 0) begin : g_unmasked
         assign elig[j] = pend[j];
      end else begin : g_masked
         assign elig[j] = pend[j] & ~ibit;
      end
   end

   always_comb begin
      win = '0;
      for (int j = NPEND - 1; j >= 0; j--) begin
         if (elig[j]) win = CODE_W'(j);
      end
   end

   assign any = |elig;

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_seq_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 8,
   parameter int                CODE_W   = 4,
   parameter int                I_POS    = 3,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_irq,
   input  logic              start_rti,
   input  logic [CODE_W-1:0] code,
   input  logic [DATA_W-1:0] ccr_in,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] x_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [DATA_W-1:0] ccr_out,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] x_out,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic [CODE_W-1:0] code_q,
   output logic              idle,
   output logic              rti_mode,
   output logic              done
);
   localparam logic [DATA_W-1:0] IMASK = DATA_W'(1) << I_POS;
   localparam int                PAD_W = ADDR_W - CODE_W - 1;

   seq_st_t           st;
   logic [STEP_W-1:0] step;
   logic [ADDR_W-1:0] sp_cur;
   logic [ADDR_W-1:0] snap_pc;
   logic [DATA_W-1:0] snap_ccr, snap_a, snap_x, vhi;
   logic [ADDR_W-1:0] vec_addr;

   assign vec_addr = VEC_BASE - {{PAD_W{1'b0}}, code_q, 1'b0};
   assign idle     = (st == SQ_IDLE);
   assign bus_wr   = (st == SQ_PUSH);
   assign bus_rd   = (st == SQ_VHI) || (st == SQ_VLO) || (st == SQ_DUMMY) || (st == SQ_POP);

   always_comb begin
      bus_addr  = sp_cur;
      bus_wdata = '0;
      case (st)
         SQ_VHI: bus_addr = vec_addr;
         SQ_VLO: bus_addr = vec_addr + ADDR_W'(1);
         SQ_POP: bus_addr = sp_cur + ADDR_W'(1);
         SQ_PUSH: begin
            case (step)
               3'd0:    bus_wdata = snap_pc[DATA_W-1:0];
               3'd1:    bus_wdata = snap_pc[ADDR_W-1:DATA_W];
               3'd2:    bus_wdata = snap_x;
               3'd3:    bus_wdata = snap_a;
               default: bus_wdata = snap_ccr;
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         step     <= '0;
         sp_cur   <= '0;
         snap_pc  <= '0;
         snap_ccr <= '0;
         snap_a   <= '0;
         snap_x   <= '0;
         vhi      <= '0;
         code_q   <= '0;
         rti_mode <= 1'b0;
         done     <= 1'b0;
         ccr_out  <= '0;
         a_out    <= '0;
         x_out    <= '0;
         pc_out   <= '0;
         sp_out   <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (start_rti) begin
                  sp_cur   <= sp_in;
                  rti_mode <= 1'b1;
                  st       <= SQ_DUMMY;
               end else if (start_irq) begin
                  sp_cur   <= sp_in;
                  code_q   <= code;
                  snap_pc  <= pc_in;
                  snap_ccr <= ccr_in;
                  snap_a   <= a_in;
                  snap_x   <= x_in;
                  rti_mode <= 1'b0;
                  step     <= '0;
                  st       <= SQ_PUSH;
               end
            end
            SQ_PUSH: begin
               sp_cur <= sp_cur - ADDR_W'(1);
               if (step == STEP_W'(LAST_STEP)) st <= SQ_VHI;
               else step <= step + STEP_W'(1);
            end
            SQ_VHI: begin
               vhi <= bus_rdata;
               st  <= SQ_VLO;
            end
            SQ_VLO: begin
               pc_out  <= {vhi, bus_rdata};
               ccr_out <= snap_ccr | IMASK;
               a_out   <= snap_a;
               x_out   <= snap_x;
               sp_out  <= sp_cur;
               done    <= 1'b1;
               st      <= SQ_IDLE;
            end
            SQ_DUMMY: begin
               step <= '0;
               st   <= SQ_POP;
            end
            SQ_POP: begin
               sp_cur <= sp_cur + ADDR_W'(1);
               step   <= step + STEP_W'(1);
               case (step)
                  3'd0: snap_ccr <= bus_rdata;
                  3'd1: snap_a   <= bus_rdata;
                  3'd2: snap_x   <= bus_rdata;
                  3'd3: snap_pc[ADDR_W-1:DATA_W] <= bus_rdata;
                  default: begin
                     ccr_out <= snap_ccr;
                     a_out   <= snap_a;
                     x_out   <= snap_x;
                     pc_out  <= {snap_pc[ADDR_W-1:DATA_W], bus_rdata};
                     sp_out  <= sp_cur + ADDR_W'(1);
                     done    <= 1'b1;
                     st      <= SQ_IDLE;
                  end
               endcase
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
   parameter int                NUM_SRC  = 8,
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 8,
   parameter int                I_POS    = 3,
   parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC,
   localparam int               CODE_W   = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               swi_req,
   input  logic               rti_req,
   input  logic [DATA_W-1:0]  ccr_in,
   input  logic [DATA_W-1:0]  a_in,
   input  logic [DATA_W-1:0]  x_in,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic [ADDR_W-1:0]  sp_in,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [DATA_W-1:0]  bus_wdata,
   output logic               bus_wr,
   output logic               bus_rd,
   output logic [DATA_W-1:0]  ccr_out,
   output logic [DATA_W-1:0]  a_out,
   output logic [DATA_W-1:0]  x_out,
   output logic [ADDR_W-1:0]  pc_out,
   output logic [ADDR_W-1:0]  sp_out,
   output logic [CODE_W-1:0]  vec_code,
   output logic               busy,
   output logic               done
);
   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_stack_seq: NUM_SRC must be at least 1");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("irq_stack_seq: ADDR_W must be twice DATA_W");
   end
   if (I_POS >= DATA_W) begin : g_bad_ipos
      $error("irq_stack_seq: I_POS outside the CCR byte");
   end
   if (ADDR_W < CODE_W + 2) begin : g_bad_code
      $error("irq_stack_seq: address too narrow for vector codes");
   end

   logic              any_pend;
   logic              idle;
   logic              take;
   logic              start_rti;
   logic              rti_mode;
   logic [CODE_W-1:0] win;

   assign start_rti = idle & rti_req;
   assign take      = idle & ~rti_req & any_pend;
   assign busy      = ~idle;

   irq_latch_arb #(
      .NUM_SRC (NUM_SRC),
      .CODE_W  (CODE_W)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req),
      .swi   (swi_req),
      .ibit  (ccr_in[I_POS]),
      .take  (take),
      .any   (any_pend),
      .win   (win)
   );

   irq_seq_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CODE_W   (CODE_W),
      .I_POS    (I_POS),
      .VEC_BASE (VEC_BASE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_irq (take),
      .start_rti (start_rti),
      .code      (win),
      .ccr_in    (ccr_in),
      .a_in      (a_in),
      .x_in      (x_in),
      .pc_in     (pc_in),
      .sp_in     (sp_in),
      .bus_rdata (bus_rdata),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .ccr_out   (ccr_out),
      .a_out     (a_out),
      .x_out     (x_out),
      .pc_out    (pc_out),
      .sp_out    (sp_out),
      .code_q    (vec_code),
      .idle      (idle),
      .rti_mode  (rti_mode),
      .done      (done)
   );

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CODE_W = 4,
   parameter int I_POS  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              busy,
   input logic              done,
   input logic              rti_mode,
   input logic [CODE_W-1:0] vec_code,
   input logic [DATA_W-1:0] ccr_out
);
   // R10
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   // R5
   push_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && $past(bus_wr) |-> bus_addr == ADDR_W'($past(bus_addr) - ADDR_W'(1)));

   // R8
   read_asc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && $past(bus_rd) |-> bus_addr == ADDR_W'($past(bus_addr) + ADDR_W'(1)));

   // R7
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(vec_code));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

   // R6
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !rti_mode |-> ccr_out[I_POS]);

endmodule

bind irq_stack_seq irq_stack_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CODE_W (CODE_W),
   .I_POS  (I_POS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .busy     (busy),
   .done     (done),
   .rti_mode (rti_mode),
   .vec_code (vec_code),
   .ccr_out  (ccr_out)
);

// File: tb/sim_irq_stack_seq.sv
`timescale 1ns/1ps
module sim_irq_stack_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_req = '0;
   logic        swi_req = 1'b0;
   logic        rti_req = 1'b0;
   logic [7:0]  ccr_in = '0, a_in = '0, x_in = '0;
   logic [15:0] pc_in = '0, sp_in = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_wr, bus_rd;
   logic [7:0]  ccr_out, a_out, x_out;
   logic [15:0] pc_out, sp_out;
   logic [3:0]  vec_code;
   logic        busy, done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int wn = 0;
   logic [7:0]  mem [256];
   logic [15:0] wlog [64];

   always #5 clk = ~clk;

   irq_stack_seq u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_req(swi_req),
      .rti_req(rti_req), .ccr_in(ccr_in), .a_in(a_in), .x_in(x_in),
      .pc_in(pc_in), .sp_in(sp_in), .bus_rdata(bus_rdata),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .ccr_out(ccr_out), .a_out(a_out), .x_out(x_out),
      .pc_out(pc_out), .sp_out(sp_out), .vec_code(vec_code),
      .busy(busy), .done(done));

   function automatic logic [7:0] vbyte(input logic [15:0] ad);
      return ad[7:0] ^ 8'hA5;
   endfunction

   assign bus_rdata = (bus_addr[15:8] == 8'hFF) ? vbyte(bus_addr) : mem[bus_addr[7:0]];

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (bus_wr) begin
         mem[bus_addr[7:0]] <= bus_wdata;
         wlog[wn % 64] <= bus_addr;
         wn <= wn + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait (cyc > 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_req = '0; swi_req = 1'b0; rti_req = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // returns the number of rising edges seen until done is high
   task automatic wait_done(output int n);
      n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic logic [15:0] vec_pc(input int code);
      logic [15:0] va;
      va = 16'hFFFC - 16'(2 * code);
      return {vbyte(va), vbyte(va + 16'd1)};
   endfunction

   // {irq[7:0], swi, mask, code[3:0]}
   localparam logic [13:0] TAB [7] = '{
      {8'h01, 1'b0, 1'b0, 4'd1},
      {8'h80, 1'b0, 1'b0, 4'd8},
      {8'h28, 1'b0, 1'b0, 4'd4},
      {8'hFF, 1'b0, 1'b0, 4'd1},
      {8'h04, 1'b1, 1'b1, 4'd0},
      {8'h00, 1'b1, 1'b0, 4'd0},
      {8'h30, 1'b0, 1'b0, 4'd5}
   };

   initial begin
      int n;
      logic [15:0] sp0, pc0;
      logic [7:0]  ccr0, a0, x0;
      int b;

      // R1 reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 bus", {bus_wr, bus_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 sp_out", sp_out, 0);
      check("R1 busy after release", busy, 0);

      for (int k = 0; k < 7; k++) begin
         do_reset();
         sp0  = 16'h0080;
         pc0  = 16'h1230 + 16'(k);
         a0   = 8'h40 + 8'(k);
         x0   = 8'h90 + 8'(k);
         ccr0 = 8'h61 | (TAB[k][4] ? 8'h08 : 8'h00);
         ccr_in = ccr0; a_in = a0; x_in = x0; pc_in = pc0; sp_in = sp0;
         irq_req = TAB[k][13:6]; swi_req = TAB[k][5];
         b = wn;
         @(negedge clk);
         irq_req = '0; swi_req = 1'b0;
         wait_done(n);
         check("R3 code", vec_code, 32'(TAB[k][3:0]));
         check("R4 vector pc", pc_out, vec_pc(int'(TAB[k][3:0])));
         check("R6 sp", sp_out, 16'h007B);
         check("R6 ccr mask set", ccr_out, ccr0 | 8'h08);
         check("R6 a", a_out, a0);
         check("R6 x", x_out, x0);
         check("R5 pcl", mem[8'h80], pc0[7:0]);
         check("R5 pch", mem[8'h7F], pc0[15:8]);
         check("R5 x", mem[8'h7E], x0);
         check("R5 a", mem[8'h7D], a0);
         check("R5 ccr", mem[8'h7C], ccr0);
         check("R5 first addr", wlog[b % 64], 16'h0080);
         // R8 return
         ccr_in = 8'h08; a_in = 8'h00; x_in = 8'h00; pc_in = 16'h0; sp_in = sp_out;
         rti_req = 1'b1;
         @(negedge clk);
         rti_req = 1'b0;
         wait_done(n);
         check("R8 ccr restored", ccr_out, ccr0);
         check("R8 a", a_out, a0);
         check("R8 x", x_out, x0);
         check("R8 pc", pc_out, pc0);
         check("R8 sp", sp_out, sp0);
      end

      // R10 entry latency
      do_reset();
      ccr_in = 8'h00; sp_in = 16'h0080;
      irq_req = 8'h04;
      @(negedge clk);
      irq_req = '0;
      n = 1;
      while (!done && n < 50) begin @(negedge clk); n++; end
      check("R10 entry edges", n, 9);
      @(negedge clk);
      check("R10 done one cycle", done, 0);
      // R10 return latency
      sp_in = sp_out; rti_req = 1'b1;
      @(negedge clk);
      rti_req = 1'b0;
      n = 1;
      while (!done && n < 50) begin @(negedge clk); n++; end
      check("R10 return edges", n, 7);

      // R2 masked request waits
      do_reset();
      ccr_in = 8'h08; sp_in = 16'h0080;
      irq_req = 8'h02;
      @(negedge clk);
      irq_req = '0;
      repeat (10) @(negedge clk);
      check("R2 held while masked", busy, 0);
      ccr_in = 8'h00;
      wait_done(n);
      check("R2 serviced after unmask", vec_code, 2);

      // R7 no displacement, R11 return first
      do_reset();
      ccr_in = 8'h00; sp_in = 16'h0080; pc_in = 16'h4455;
      irq_req = 8'h20;
      @(negedge clk);
      irq_req = '0;
      while (!busy) @(negedge clk);
      irq_req = 8'h01;
      @(negedge clk);
      irq_req = '0;
      wait_done(n);
      check("R7 running code kept", vec_code, 6);
      sp_in = sp_out; ccr_in = 8'h00; rti_req = 1'b1;
      @(negedge clk);
      rti_req = 1'b0;
      wait_done(n);
      check("R11 return taken first sp", sp_out, 16'h0080);
      check("R11 return taken first pc", pc_out, 16'h4455);
      wait_done(n);
      @(negedge clk);
      wait_done(n);
      check("R7 late request serviced", vec_code, 1);

      // R9 wrap
      do_reset();
      ccr_in = 8'h00; sp_in = 16'h0002;
      b = wn;
      irq_req = 8'h80;
      @(negedge clk);
      irq_req = '0;
      wait_done(n);
      check("R9 sp wrap", sp_out, 16'hFFFD);
      check("R9 addr 3", wlog[(b + 2) % 64], 16'h0000);
      check("R9 addr 4", wlog[(b + 3) % 64], 16'hFFFF);
      check("R9 addr 5", wlog[(b + 4) % 64], 16'hFFFE);

      finish_run();
   end
endmodule